// File: doc/BRIEF.md
# FIFO Readout Pattern Checker

This block empties a receive FIFO that has a one-cycle read latency, pulling a word in every cycle the FIFO reports data present. Each word is registered once more and then compared against an expected sequence that starts at zero and climbs by one per word. Any mismatch seen while checking is switched on sets a failure flag that stays high until software issues a command write or the block is reset.

A running count of received bytes is kept alongside, growing by four per word popped. Writing the command port loads the check-enable bit, clears the byte count and clears the failure flag. A separate soft-clear pulse restarts the expected sequence at zero so that a new test stream can begin without disturbing the other state.

The FIFO side applies no back-pressure toward the FIFO: the read strobe is the only ready-like signal, and it is high exactly when the FIFO is not empty. The FIFO must therefore accept a pop in any cycle it shows data, and it must present the popped word on its data pins in the following cycle.

Top module: `pchk_top`

## Requirements
- R1: `fifo_rd_en` is high in exactly the cycles where `fifo_empty` is low, in the same cycle, with no register between them.
- R2: A word popped at clock edge k is captured at edge k+1 and compared during the cycle after; a resulting change of `fail` is visible after edge k+2.
- R3: The expected value is 0 for the first word after reset or soft clear and rises by one (modulo 2^32) for every word popped, whether or not checking is on; a command write does not restart it.
- R4: When `verify_en` is 1 and a compared word differs from the expected value, `fail` becomes 1 and stays 1 until a command write or reset.
- R5: When `verify_en` is 0, `fail` never rises, while words are still popped, counted and advance the expected value.
- R6: `rx_bytes` rises by 4 in the cycle after each pop and holds otherwise.
- R7: A command write sets `rx_bytes` and `fail` to 0 after the next edge; the clear wins over a pop or a mismatch in the same cycle.
- R8: A command write loads `cmd_verify` into `verify_en` (1 enables checking, 0 disables it); `verify_en` holds between writes.
- R9: A `soft_clr` pulse returns the expected value to 0 and leaves `rx_bytes`, `fail` and `verify_en` unchanged.
- R10: After reset `fail`, `verify_en` and `rx_bytes` are 0 and the expected value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Pulse: restart the expected sequence at 0 |
| fifo_empty | input | 1 | FIFO has no data |
| fifo_rd_en | output | 1 | FIFO pop strobe |
| fifo_rd_data | input | 32 | FIFO read word, valid one cycle after a pop |
| cmd_wr | input | 1 | Command write strobe |
| cmd_verify | input | 1 | Check-enable value taken on a command write |
| verify_en | output | 1 | Current check-enable state |
| fail | output | 1 | Sticky mismatch flag |
| rx_bytes | output | 32 | Received byte count |

## Verification
The hardest situation to reach from the ports is a command write landing in the very cycle a mismatching word is being compared, where the clear must beat the set. The bench holds its own FIFO model with a known pop latency, pushes a wrong word into an empty FIFO and times the command write to cover the third edge after the push. The exact three-edge latency of the failure flag is measured the same way, and a disabled-checking stream of wrong words shows the expected value still advancing once checking is switched back on.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_CNT_W  = 32;
  // pipeline stages between pop and compare
  localparam int CMP_LAT    = 2;

  function automatic int bytes_per_word(input int data_w);
    return data_w / 8;
  endfunction
endpackage

// File: rtl/pchk_fetch.sv
module pchk_fetch #(
  parameter int DATA_W = pchk_pkg::DEF_DATA_W,
  parameter int LAT    = pchk_pkg::CMP_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              fifo_rd_en,
  output logic              cmp_vld,
  output logic [DATA_W-1:0] cmp_data
);
  logic [LAT:0] vld_dly;
  logic [DATA_W-1:0] data_q;

  assign fifo_rd_en = ~fifo_empty;
  assign vld_dly[0] = fifo_rd_en;

  for (genvar s = 1; s <= LAT; s++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_dly[s] <= 1'b0;
      else        vld_dly[s] <= vld_dly[s-1];
    end
  end

  // FIFO data is live in the cycle after the pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_q <= '0;
    else if (vld_dly[1]) data_q <= fifo_rd_data;
  end

  assign cmp_vld  = vld_dly[LAT];
  assign cmp_data = data_q;
endmodule

// File: rtl/pchk_pattern.sv
module pchk_pattern #(
  parameter int DATA_W = pchk_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  output logic [DATA_W-1:0] exp_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exp_word <= '0;
    else if (restart) exp_word <= '0;
    else if (step)    exp_word <= exp_word + DATA_W'(1);
  end
endmodule

// File: rtl/pchk_bytecnt.sv
module pchk_bytecnt #(
  parameter int CNT_W = pchk_pkg::DEF_CNT_W,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + STEP_V;
  end
endmodule

// File: rtl/pchk_top.sv
module pchk_top #(
  parameter int DATA_W = pchk_pkg::DEF_DATA_W,
  parameter int CNT_W  = pchk_pkg::DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              cmd_wr,
  input  logic              cmd_verify,
  output logic              verify_en,
  output logic              fail,
  output logic [CNT_W-1:0]  rx_bytes
);
  localparam int BPW = pchk_pkg::bytes_per_word(DATA_W);

  logic              cmp_vld;
  logic [DATA_W-1:0] cmp_data;
  logic [DATA_W-1:0] exp_word;
  logic              mismatch;

  pchk_fetch #(.DATA_W(DATA_W), .LAT(pchk_pkg::CMP_LAT)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en),
    .cmp_vld(cmp_vld), .cmp_data(cmp_data)
  );

  pchk_pattern #(.DATA_W(DATA_W)) u_pattern (
    .clk(clk), .rst_n(rst_n), .restart(soft_clr),
    .step(cmp_vld), .exp_word(exp_word)
  );

  pchk_bytecnt #(.CNT_W(CNT_W), .STEP(BPW)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clr(cmd_wr),
    .inc(fifo_rd_en), .count(rx_bytes)
  );

  assign mismatch = cmp_vld && verify_en && (cmp_data != exp_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      verify_en <= 1'b0;
    else if (cmd_wr) verify_en <= cmd_verify;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail <= 1'b0;
    else if (cmd_wr)   fail <= 1'b0;
    else if (mismatch) fail <= 1'b1;
  end
endmodule

// File: rtl/pchk_props.sv
module pchk_props #(
  parameter int CNT_W = pchk_pkg::DEF_CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_empty,
  input logic             fifo_rd_en,
  input logic             cmd_wr,
  input logic             cmd_verify,
  input logic             verify_en,
  input logic             fail,
  input logic [CNT_W-1:0] rx_bytes
);
  assert_pop_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_rd_en);
  assert_pop_avail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_empty |-> fifo_rd_en);
  assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !cmd_wr) |=> fail);
  assert_no_fail_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!verify_en && !fail) |=> !fail);
  assert_bytes_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_en && !cmd_wr) |=> rx_bytes == $past(rx_bytes) + CNT_W'(4));
  assert_bytes_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_rd_en && !cmd_wr) |=> $stable(rx_bytes));
  assert_cmd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (!fail && rx_bytes == '0));
  assert_en_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> verify_en == $past(cmd_verify));
  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(verify_en));
endmodule

bind pchk_top pchk_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en),
  .cmd_wr(cmd_wr), .cmd_verify(cmd_verify), .verify_en(verify_en),
  .fail(fail), .rx_bytes(rx_bytes)
);

// File: tb/test_pchk_top.sv
`timescale 1ns/1ps
module test_pchk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic        fifo_empty;
  logic        fifo_rd_en;
  logic [31:0] fifo_rd_data = '0;
  logic        cmd_wr = 1'b0;
  logic        cmd_verify = 1'b0;
  logic        verify_en;
  logic        fail;
  logic [31:0] rx_bytes;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // FIFO model: one-cycle read latency
  logic [31:0] mem [0:255];
  logic [7:0]  head = '0;
  logic [7:0]  tail = '0;
  int unsigned exp_idx = 0;

  always #2 clk = ~clk;

  assign fifo_empty = (head == tail);

  always @(posedge clk) begin
    if (fifo_rd_en) begin
      fifo_rd_data <= mem[head];
      head <= head + 8'd1;
    end
  end

  pchk_top i_pchk_top (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en),
    .fifo_rd_data(fifo_rd_data), .cmd_wr(cmd_wr), .cmd_verify(cmd_verify),
    .verify_en(verify_en), .fail(fail), .rx_bytes(rx_bytes)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge
  task automatic push(input logic [31:0] w);
    mem[tail] = w;
    tail = tail + 8'd1;
    exp_idx++;
  endtask

  task automatic cmd(input logic v);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_verify = v;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 fail", fail, 0);
    check("R10 verify_en", verify_en, 0);
    check("R10 rx_bytes", rx_bytes, 0);
    check("R1 idle rd_en", fifo_rd_en, 0);
  endtask

  task automatic t_enable;
    cmd(1'b1);
    check("R8 enable load", verify_en, 1);
    check("R7 count after cmd", rx_bytes, 0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    push(exp_idx);
    #0.5;
    check("R1 rd_en follows not-empty", fifo_rd_en, 1);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      push(exp_idx);
    end
    idle(5);
    check("R3 good stream no fail", fail, 0);
    check("R6 bytes after 10 words", rx_bytes, 40);
  endtask

  task automatic t_latency;
    @(negedge clk);
    push(32'd99);
    @(negedge clk);
    check("R2 fail low after pop edge", fail, 0);
    @(negedge clk);
    check("R2 fail low after capture edge", fail, 0);
    @(negedge clk);
    check("R2 R4 fail high after compare edge", fail, 1);
  endtask

  task automatic t_sticky;
    @(negedge clk); push(exp_idx);
    @(negedge clk); push(exp_idx);
    idle(5);
    check("R4 fail sticky", fail, 1);
    check("R6 bytes 13 words", rx_bytes, 52);
  endtask

  task automatic t_cmd_clear;
    cmd(1'b1);
    check("R7 fail cleared", fail, 0);
    check("R7 bytes cleared", rx_bytes, 0);
    @(negedge clk); push(exp_idx);
    idle(5);
    check("R3 pattern kept across cmd", fail, 0);
  endtask

  task automatic t_disabled;
    cmd(1'b0);
    check("R8 disable load", verify_en, 0);
    @(negedge clk); push(32'd500);
    @(negedge clk); push(32'd501);
    idle(5);
    check("R5 no fail when off", fail, 0);
    check("R5 still counted", rx_bytes, 8);
    cmd(1'b1);
    @(negedge clk); push(exp_idx);
    idle(5);
    check("R5 R3 pattern advanced while off", fail, 0);
  endtask

  task automatic t_soft;
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    exp_idx = 0;
    check("R9 en kept", verify_en, 1);
    check("R9 bytes kept", rx_bytes, 4);
    check("R9 fail kept", fail, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); push(exp_idx);
    end
    idle(5);
    check("R9 restart at zero", fail, 0);
    check("R6 bytes after soft", rx_bytes, 16);
  endtask

  task automatic t_clear_priority;
    @(negedge clk);
    push(exp_idx);
    cmd_wr = 1'b1; cmd_verify = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check("R7 clear beats pop", rx_bytes, 0);
    idle(4);
    @(negedge clk);
    push(32'd77);
    idle(2);
    cmd_wr = 1'b1; cmd_verify = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check("R7 clear beats mismatch", fail, 0);
    idle(3);
    check("R7 fail stays clear", fail, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_stream();
    t_latency();
    t_sticky();
    t_cmd_clear();
    t_disabled();
    t_soft();
    t_clear_priority();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule